// File: doc/BRIEF.md
# Gamma Lookup and Binary Threshold Stage

This block is a streaming point operation for single-channel 8-bit pixels. Each pixel goes through a programmable correction table indexed by the pixel value. The corrected value is then compared against a fixed level, which turns the pixel into black or white. The table lookup and the comparison sit in two separate register stages, so the stage accepts one pixel per clock while the downstream consumer keeps up.

Pixels enter and leave through valid/ready handshakes. An end-of-line marker travels alongside each pixel through both stages. Software or a loader loads the table through a simple address/data/write-enable port while the stream is idle. After reset the table holds the identity mapping, so the stage is a plain thresholder until the table is reloaded.

Top module: `gamma_thresh_stage`

## Requirements
- R1: In the first cycle after reset is released, out_valid is 0 and in_ready is 1.
- R2: After reset every table entry i holds the value i (identity mapping).
- R3: A pixel p leaves as 255 when table[p] is strictly greater than 128 and as 0 otherwise; a corrected value of 128 gives 0 and 129 gives 255.
- R4: With out_ready held high, a pixel accepted in cycle c (in_valid and in_ready both 1) is presented with out_valid = 1 in cycle c+2 and not in cycle c+1.
- R5: in_ready is 1 in every cycle where out_ready is 1, so a stream of one pixel per clock is accepted without gaps; in_ready is 0 only when both stages hold pixels and the output is stalled.
- R6: If out_valid is 1 and out_ready is 0 in a cycle, then in the next cycle out_valid is still 1 and out_pix and out_eol are unchanged.
- R7: Every accepted pixel is delivered exactly once, in acceptance order; nothing is dropped or duplicated.
- R8: out_eol equals the in_eol value that was presented with the same pixel.
- R9: A table write (tbl_wr_en = 1) in a cycle where in_valid is 0 and no accepted pixel is still waiting to leave sets entry tbl_wr_addr to tbl_wr_data for all later pixels.
- R10: A table write in a cycle where in_valid is 1 or an accepted pixel is still waiting to leave is ignored and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Stage can take a pixel this cycle |
| in_pix | input | 8 | Input pixel value |
| in_eol | input | 1 | Input pixel is the last of its line |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_pix | output | 8 | Binary result, 0 or 255 |
| out_eol | output | 1 | End-of-line marker of the output pixel |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 8 | Table entry to write |
| tbl_wr_data | input | 8 | Corrected value to store |

## Verification
A wrong table entry stays hidden until a pixel with that value arrives. It then shows two cycles later as an inverted binary output, but only if the bad entry falls on the other side of the threshold. For that reason the bench loads random tables and sends many different pixel values. A fault in the stage-valid registers shows within a cycle or two as a lost, repeated or reordered pixel, or as an output that changes during a stall. A write that reaches the table while the stream is busy only shows on a later pixel that uses the affected entry. The bench therefore reads back through the stream right after the stream drains.

// File: rtl/gthr_pkg.sv
// Package: shared types for the gamma/threshold pixel stage.
// Assumes: no user beyond the gthr_* modules.
package gthr_pkg;

    // Sideband carried by each pipeline stage next to the pixel value.
    typedef struct packed {
        logic vld;
        logic eol;
    } gthr_side_t;

    // Default pixel width for the stage.
    localparam int unsigned GTHR_PIX_W = 8;

endpackage

// File: rtl/gthr_flow_ctrl.sv
// Module: gthr_flow_ctrl
// Holds the valid bits of the two register stages and derives the load
// enables from downstream backpressure. A stage loads when it is empty or
// when the stage after it loads in the same cycle.
// Assumes: the data modules load exactly when the enables given here are high.
module gthr_flow_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic accept,
    output logic ld1,
    output logic ld2,
    output logic s1_vld,
    output logic s2_vld,
    output logic busy
);

    // Load enables, computed from the output end backwards.
    always_comb begin
        ld2      = !s2_vld || out_ready;
        ld1      = !s1_vld || ld2;
        in_ready = ld1;
        accept   = in_valid && ld1;
        busy     = in_valid || s1_vld || s2_vld;
    end

    // Stage valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s2_vld <= 1'b0;
        end else begin
            if (ld1) s1_vld <= in_valid;
            if (ld2) s2_vld <= s1_vld;
        end
    end

    // R5: an open output never blocks the input.
    assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
    // R4: an accepted pixel occupies stage 1 in the next cycle.
    assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> s1_vld);
    // R4: a moving stage-1 pixel occupies stage 2 in the next cycle.
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && ld2) |=> s2_vld);
    // R6: a stalled output pixel stays presented.
    assert_keep_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && !out_ready) |=> s2_vld);

endmodule

// File: rtl/gthr_lut.sv
// Module: gthr_lut
// Correction table with 2**PIX_W entries and the stage-1 register. The read
// is synchronous: on an accepted pixel the entry it indexes is registered.
// Writes commit only when the stream is idle.
// Assumes: busy is high while any pixel is offered or in flight.
module gthr_lut #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [PIX_W-1:0] rd_addr,
    input  logic             rd_eol,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [PIX_W-1:0] wr_addr,
    input  logic [PIX_W-1:0] wr_data,
    output logic [PIX_W-1:0] s1_val,
    output logic             s1_eol
);

    localparam int unsigned DEPTH = 1 << PIX_W;

    logic [PIX_W-1:0] mem [DEPTH];
    logic             wr_commit;

    // A write takes effect only while the stream is idle.
    always_comb wr_commit = wr_en && !busy;

    // Table storage: identity at reset, idle-time writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= PIX_W'(i);
        end else if (wr_commit) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Stage-1 register: corrected value and its end-of-line flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_val <= '0;
            s1_eol <= 1'b0;
        end else if (accept) begin
            s1_val <= mem[rd_addr];
            s1_eol <= rd_eol;
        end
    end

    // R10: no table update in a cycle that takes a pixel.
    assert_no_write_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !wr_commit);
    // R9: a committed write is visible in the next cycle.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/gthr_binarize.sv
// Module: gthr_binarize
// Stage-2 register: compares the corrected value with THRESH and registers
// either all-ones or zero, together with the end-of-line flag.
// Assumes: ld is high exactly when stage 2 may take new contents.
module gthr_binarize #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned THRESH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PIX_W-1:0] in_val,
    input  logic             in_eol,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_eol
);

    localparam logic [PIX_W-1:0] LEVEL = PIX_W'(THRESH);
    localparam logic [PIX_W-1:0] HIGH  = {PIX_W{1'b1}};

    logic [PIX_W-1:0] bin_val;

    // Strictly-greater comparison picks the binary level.
    always_comb bin_val = (in_val > LEVEL) ? HIGH : '0;

    // Stage-2 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pix <= '0;
            out_eol <= 1'b0;
        end else if (ld) begin
            out_pix <= bin_val;
            out_eol <= in_eol;
        end
    end

endmodule

// File: rtl/gamma_thresh_stage.sv
// Module: gamma_thresh_stage
// Streaming pixel stage: correction-table lookup (stage 1), then hard
// binarisation against THRESH (stage 2). One pixel per clock with
// valid/ready on both sides, and a table write port used while idle.
// Assumes: THRESH fits in PIX_W bits.
module gamma_thresh_stage #(
    parameter int unsigned PIX_W  = gthr_pkg::GTHR_PIX_W,
    parameter int unsigned THRESH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_eol,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_eol,
    input  logic             tbl_wr_en,
    input  logic [PIX_W-1:0] tbl_wr_addr,
    input  logic [PIX_W-1:0] tbl_wr_data
);

    import gthr_pkg::*;

    localparam logic [PIX_W-1:0] HIGH = {PIX_W{1'b1}};

    logic             accept, ld1, ld2, busy;
    gthr_side_t       s1_side, s2_side;
    logic [PIX_W-1:0] s1_val;

    gthr_flow_ctrl u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .accept   (accept),
        .ld1      (ld1),
        .ld2      (ld2),
        .s1_vld   (s1_side.vld),
        .s2_vld   (s2_side.vld),
        .busy     (busy)
    );

    gthr_lut #(.PIX_W(PIX_W)) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .rd_addr(in_pix),
        .rd_eol (in_eol),
        .busy   (busy),
        .wr_en  (tbl_wr_en),
        .wr_addr(tbl_wr_addr),
        .wr_data(tbl_wr_data),
        .s1_val (s1_val),
        .s1_eol (s1_side.eol)
    );

    gthr_binarize #(.PIX_W(PIX_W), .THRESH(THRESH)) u_bin (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld2),
        .in_val (s1_val),
        .in_eol (s1_side.eol),
        .out_pix(out_pix),
        .out_eol(s2_side.eol)
    );

    // Output port mapping.
    always_comb begin
        out_valid = s2_side.vld;
        out_eol   = s2_side.eol;
    end

    // R3: a presented pixel is one of the two binary levels.
    assert_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pix == '0 || out_pix == HIGH));
    // R6: a stalled output keeps its pixel and flag.
    assert_stall_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_pix) && $stable(out_eol)));
    // R1: nothing presented right after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/tb_gamma_thresh_stage.sv
`timescale 1ns/1ps
module tb_gamma_thresh_stage;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_eol;
    logic [7:0] in_pix;
    logic       out_valid, out_ready, out_eol;
    logic [7:0] out_pix;
    logic       tbl_wr_en;
    logic [7:0] tbl_wr_addr, tbl_wr_data;

    always #2 clk = ~clk;

    gamma_thresh_stage dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_eol(out_eol),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data)
    );

    int         n_tests = 0;
    int         n_fail  = 0;
    bit         finished = 0;
    logic [7:0] model [256];
    logic [8:0] expq [$];
    string      sb_tag = "R3 R7 R8";
    logic       last_outv, last_inrdy, last_acc;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_pix;
    logic       prev_eol;

    // Expected binary output for a corrected value (R3).
    function automatic logic [7:0] exp_bin(input logic [7:0] v);
        return (v > 8'd128) ? 8'd255 : 8'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, observe, update the model.
    task automatic tick(input logic v, input logic [7:0] p, input logic e,
                        input logic r, input logic we,
                        input logic [7:0] wa, input logic [7:0] wd);
        logic [8:0] front;
        in_valid = v; in_pix = p; in_eol = e; out_ready = r;
        tbl_wr_en = we; tbl_wr_addr = wa; tbl_wr_data = wd;
        #1;
        if (prev_stall) begin
            chk(out_valid === 1'b1, "R6 valid kept", int'(out_valid), 1);
            chk(out_pix === prev_pix && out_eol === prev_eol, "R6 data kept",
                int'({out_eol, out_pix}), int'({prev_eol, prev_pix}));
        end
        if (r) chk(in_ready === 1'b1, "R5 ready", int'(in_ready), 1);
        if (we && !v && expq.size() == 0) model[wa] = wd;
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R7 extra output", int'(out_pix), -1);
            end else begin
                front = expq.pop_front();
                chk({out_eol, out_pix} === front, sb_tag,
                    int'({out_eol, out_pix}), int'(front));
            end
        end
        last_acc = v && in_ready;
        if (last_acc) expq.push_back({e, exp_bin(model[p])});
        last_outv  = out_valid;
        last_inrdy = in_ready;
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pix;
        prev_eol   = out_eol;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 8'd0, 0, 1, 0, 8'd0, 8'd0);
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = 8'(i);
        rst_n = 1'b0;
        in_valid = 0; in_pix = 0; in_eol = 0; out_ready = 0;
        tbl_wr_en = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
        @(negedge clk);

        // R2 and R3: identity table and threshold edges
        sb_tag = "R2 R3 R8";
        tick(1, 8'd128, 0, 1, 0, 0, 0);
        tick(1, 8'd129, 1, 1, 0, 0, 0);
        tick(1, 8'd0,   0, 1, 0, 0, 0);
        tick(1, 8'd255, 1, 1, 0, 0, 0);
        idle(4);

        // R4: two-cycle latency
        sb_tag = "R4 R3";
        tick(1, 8'd200, 0, 1, 0, 0, 0);
        chk(last_acc === 1'b1, "R4 accept", int'(last_acc), 1);
        tick(0, 8'd0, 0, 1, 0, 0, 0);
        chk(last_outv === 1'b0, "R4 not at c+1", int'(last_outv), 0);
        tick(0, 8'd0, 0, 1, 0, 0, 0);
        chk(last_outv === 1'b1, "R4 valid at c+2", int'(last_outv), 1);
        idle(2);

        // R5: back-to-back stream, none refused
        sb_tag = "R5 R7 R8";
        for (int i = 0; i < 12; i++) begin
            tick(1, 8'(i * 23), i[0], 1, 0, 0, 0);
            chk(last_acc === 1'b1, "R5 back-to-back", int'(last_acc), 1);
        end
        idle(3);

        // R9: idle-time writes take effect
        sb_tag = "R9 R3";
        tick(0, 0, 0, 1, 1, 8'd10, 8'd200);
        tick(0, 0, 0, 1, 1, 8'd200, 8'd5);
        tick(1, 8'd10, 0, 1, 0, 0, 0);
        tick(1, 8'd200, 1, 1, 0, 0, 0);
        idle(3);
        chk(model[10] == 8'd200, "R9 model", int'(model[10]), 200);

        // R5, R6, R10: fill under stall, write while busy, then drain
        sb_tag = "R6 R7 R8";
        tick(1, 8'd10, 1, 0, 0, 0, 0);
        tick(1, 8'd200, 0, 0, 0, 0, 0);
        tick(1, 8'd129, 1, 0, 0, 0, 0);
        chk(last_inrdy === 1'b0, "R5 full and stalled", int'(last_inrdy), 0);
        tick(0, 0, 0, 0, 1, 8'd10, 8'd0);
        tick(1, 8'd7, 0, 0, 1, 8'd10, 8'd0);
        tick(0, 0, 0, 0, 0, 0, 0);
        idle(4);
        sb_tag = "R10 R7";
        tick(1, 8'd10, 0, 1, 0, 0, 0);
        idle(3);
        chk(model[10] == 8'd200, "R10 model unchanged", int'(model[10]), 200);

        // Random table load while idle
        for (int i = 0; i < 256; i++)
            tick(0, 0, 0, 1, 1, 8'(i), 8'($urandom_range(0, 255)));

        // Random traffic with random backpressure and stray writes
        sb_tag = "R3 R7 R8 R10";
        for (int i = 0; i < 4000; i++) begin
            tick(($urandom_range(0, 9) < 7), 8'($urandom_range(0, 255)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 9) < 7),
                 ($urandom_range(0, 9) == 0), 8'($urandom_range(0, 255)),
                 8'($urandom_range(0, 255)));
        end
        idle(6);
        chk(expq.size() == 0, "R7 all delivered", expq.size(), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule